// File: doc/BRIEF.md
# Single-Cycle RISC ALU Instruction Executor

This block decodes and retires one fixed-format 32-bit arithmetic or logic instruction per clock. It holds a 32-entry register file in which the highest register is hardwired to zero. An instruction presented with its valid strobe reads two operands and computes a result. The result is written back at the next rising edge, so the instruction that follows in the next cycle already sees it.

Every instruction keeps its fields in the same places. The opcode's second bit decides whether the second operand is a register or a sign-extended 16-bit literal. The low four opcode bits name the operation. A debug port reads any register combinationally. A one-cycle flag reports an opcode that the block does not implement.

Top module: `risc_alu_exec`

## Requirements
- R1: While reset (rst_n low) is held, and after it is released, every register reads zero on the debug port and `illegal` is low.
- R2: Fields sit at fixed positions: opcode in bits 31:26, destination rc in 25:21, first source ra in 20:16, second source rb in 15:11. Opcode 100000 (0x80611000 = rc 3, ra 1, rb 2) writes ra+rb into rc.
- R3: Opcode bit 30 set selects the literal in bits 15:0, sign-extended, as the second operand. 0xC061FFFD adds -3 to r1 and writes the sum into r3.
- R4: Function code 0001 gives ra minus operand two. Function code 0010 gives the low 32 bits of the product.
- R5: Function codes 0100, 0101 and 0110 compare for equal, signed less-than and signed less-or-equal. Each writes 1 when true and 0 when false.
- R6: Function codes 1000, 1001 and 1010 give bitwise and, or and xor. In the literal form the literal is sign-extended first.
- R7: Register 31 reads as zero, both as an operand and on the debug port. A write that targets it is discarded.
- R8: An opcode whose bit 31 is clear, or whose function code is not in the set above, changes no register. It raises `illegal` for exactly the following cycle.
- R9: An instruction with `instr_valid` low changes no register and does not raise `illegal`.
- R10: A result is readable by the instruction issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| dbg_sel | input | 5 | Register index for debug read |
| dbg_val | output | DATA_W (32) | Contents of the selected register |
| illegal | output | 1 | Previous cycle's valid instruction had an unimplemented opcode |

## Verification
Operand values are chosen so that each operation gives a result the others would not. A negative register against a positive one separates signed from unsigned comparison. Negative literals show whether sign extension was applied, and a product that overflows 32 bits tests truncation to the low word. Back-to-back dependent instructions test same-cycle forwarding through the register file. Writes to register 31, unimplemented opcodes and strobe-low words are each followed by debug reads of the register they name, to confirm that nothing changed.

// File: rtl/rax_pkg.sv
package rax_pkg;
   localparam int OPW  = 6;
   localparam int REGW = 5;
   localparam int LITW = 16;

   typedef enum logic [3:0] {
      FN_ADD   = 4'h0,
      FN_SUB   = 4'h1,
      FN_MUL   = 4'h2,
      FN_CMPEQ = 4'h4,
      FN_CMPLT = 4'h5,
      FN_CMPLE = 4'h6,
      FN_AND   = 4'h8,
      FN_OR    = 4'h9,
      FN_XOR   = 4'hA
   } alu_fn_e;

   typedef struct packed {
      alu_fn_e           fn;
      logic [REGW-1:0]   rc;
      logic [REGW-1:0]   ra;
      logic [REGW-1:0]   rb;
      logic              use_lit;
      logic [LITW-1:0]   lit;
      logic              legal;
      logic              is_cmp;
   } dec_t;
endpackage

// File: rtl/rax_decode.sv
module rax_decode
   import rax_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);
   logic [3:0] fcode;
   logic       fn_ok;

   assign fcode = instr[29:26];

   always_comb begin
      case (fcode)
         4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA: fn_ok = 1'b1;
         default: fn_ok = 1'b0;
      endcase
   end

   always_comb begin
      dec.fn      = alu_fn_e'(fcode);
      dec.rc      = instr[25:21];
      dec.ra      = instr[20:16];
      dec.rb      = instr[15:11];
      dec.use_lit = instr[30];
      dec.lit     = instr[LITW-1:0];
      dec.legal   = instr[31] && fn_ok;
      dec.is_cmp  = (fcode == 4'h4) || (fcode == 4'h5) || (fcode == 4'h6);
   end
endmodule

// File: rtl/rax_alu.sv
module rax_alu
   import rax_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_fn_e           fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   logic [DATA_W-1:0] prod;
   logic              lt_s;
   logic              eq;

   assign prod = a * b;
   assign lt_s = $signed(a) < $signed(b);
   assign eq   = (a == b);

   always_comb begin
      case (fn)
         FN_ADD:   y = a + b;
         FN_SUB:   y = a - b;
         FN_MUL:   y = prod;
         FN_CMPEQ: y = {{(DATA_W-1){1'b0}}, eq};
         FN_CMPLT: y = {{(DATA_W-1){1'b0}}, lt_s};
         FN_CMPLE: y = {{(DATA_W-1){1'b0}}, lt_s | eq};
         FN_AND:   y = a & b;
         FN_OR:    y = a | b;
         FN_XOR:   y = a ^ b;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/rax_regfile.sv
module rax_regfile
   import rax_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NREG  = 1 << REGW,
   localparam int ZREG  = NREG - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REGW-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [REGW-1:0]   ra_sel,
   input  logic [REGW-1:0]   rb_sel,
   input  logic [REGW-1:0]   dbg_sel,
   output logic [DATA_W-1:0] ra_val,
   output logic [DATA_W-1:0] rb_val,
   output logic [DATA_W-1:0] dbg_val
);
   logic [DATA_W-1:0] mem [ZREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ZREG; i++) mem[i] <= '0;
      end else if (we && (waddr != REGW'(ZREG))) begin
         mem[waddr] <= wdata;
      end
   end

   function automatic logic [DATA_W-1:0] rd(input logic [REGW-1:0] s);
      return (s == REGW'(ZREG)) ? '0 : mem[s];
   endfunction

   assign ra_val  = rd(ra_sel);
   assign rb_val  = rd(rb_sel);
   assign dbg_val = rd(dbg_sel);

   // R9: with no write in the previous cycle, a held debug index reads a held value
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!we) && $stable(dbg_sel)) |-> $stable(dbg_val));
endmodule

// File: rtl/risc_alu_exec.sv
module risc_alu_exec
   import rax_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [31:0]       instr,
   input  logic [REGW-1:0]   dbg_sel,
   output logic [DATA_W-1:0] dbg_val,
   output logic              illegal
);
   generate
      if (DATA_W <= LITW) begin : g_bad_width
         $error("DATA_W must exceed the literal width");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] ra_val, rb_val, opb, res;
   logic              rf_we;

   rax_decode u_dec (.instr(instr), .dec(dec));

   rax_regfile #(.DATA_W(DATA_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(dec.rc), .wdata(res),
      .ra_sel(dec.ra), .rb_sel(dec.rb), .dbg_sel(dbg_sel),
      .ra_val(ra_val), .rb_val(rb_val), .dbg_val(dbg_val)
   );

   assign opb = dec.use_lit ? {{(DATA_W-LITW){dec.lit[LITW-1]}}, dec.lit} : rb_val;

   rax_alu #(.DATA_W(DATA_W)) u_alu (.fn(dec.fn), .a(ra_val), .b(opb), .y(res));

   assign rf_we = instr_valid && dec.legal;

   always_ff @(posedge clk) begin
      if (!rst_n) illegal <= 1'b0;
      else        illegal <= instr_valid && !dec.legal;
   end

   // R8: an unimplemented valid opcode is flagged in the next cycle
   assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !dec.legal) |=> illegal);
   // R8: the flag only follows a strobed instruction
   assert_illegal_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(instr_valid));
   // R9: no strobe, no flag
   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> !illegal);
   // R5: compare results are a single bit
   assert_cmp_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && dec.is_cmp) |-> (res[DATA_W-1:1] == '0));
endmodule

// File: tb/tb_risc_alu_exec.sv
`timescale 1ns/1ps
module tb_risc_alu_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_val;
   logic        illegal;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   risc_alu_exec dut (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
                      .dbg_sel(dbg_sel), .dbg_val(dbg_val), .illegal(illegal));

   function automatic logic [31:0] rr(input logic [3:0] f, input logic [4:0] c,
                                      input logic [4:0] a, input logic [4:0] b);
      return {2'b10, f, c, a, b, 11'b0};
   endfunction
   function automatic logic [31:0] rk(input logic [3:0] f, input logic [4:0] c,
                                      input logic [4:0] a, input logic [15:0] k);
      return {2'b11, f, c, a, k};
   endfunction

   typedef struct packed {
      logic [31:0] ins;
      logic [4:0]  chk;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VEC [NV] = '{
      '{rk(4'h0, 5'd1, 5'd31, 16'd7),      5'd1,  32'd7,        8'd3},  // R3
      '{rk(4'h0, 5'd2, 5'd31, 16'd5),      5'd2,  32'd5,        8'd3},
      '{32'h80611000,                      5'd3,  32'd12,       8'd2},  // R2
      '{32'hC061FFFD,                      5'd3,  32'd4,        8'd3},
      '{rr(4'h1, 5'd4, 5'd2, 5'd1),        5'd4,  32'hFFFFFFFE, 8'd4},  // R4
      '{rr(4'h2, 5'd5, 5'd4, 5'd1),        5'd5,  32'hFFFFFFF2, 8'd10}, // R10
      '{rk(4'h0, 5'd6, 5'd31, 16'h7FFF),   5'd6,  32'h00007FFF, 8'd3},
      '{rr(4'h2, 5'd7, 5'd6, 5'd6),        5'd7,  32'h3FFF0001, 8'd4},
      '{rr(4'h2, 5'd8, 5'd7, 5'd7),        5'd8,  32'h7FFE0001, 8'd4},
      '{rr(4'h5, 5'd9, 5'd4, 5'd1),        5'd9,  32'd1,        8'd5},  // R5
      '{rr(4'h5, 5'd9, 5'd1, 5'd4),        5'd9,  32'd0,        8'd5},
      '{rr(4'h6, 5'd10, 5'd1, 5'd1),       5'd10, 32'd1,        8'd5},
      '{rr(4'h4, 5'd11, 5'd1, 5'd2),       5'd11, 32'd0,        8'd5},
      '{rk(4'h4, 5'd11, 5'd3, 16'd4),      5'd11, 32'd1,        8'd5},
      '{rk(4'h6, 5'd12, 5'd4, 16'hFFFE),   5'd12, 32'd1,        8'd5},
      '{rk(4'h5, 5'd12, 5'd4, 16'hFFFE),   5'd12, 32'd0,        8'd5},
      '{rk(4'h8, 5'd13, 5'd4, 16'hFFF0),   5'd13, 32'hFFFFFFF0, 8'd6},  // R6
      '{rk(4'h9, 5'd14, 5'd1, 16'h8000),   5'd14, 32'hFFFF8007, 8'd6},
      '{rr(4'hA, 5'd15, 5'd4, 5'd1),       5'd15, 32'hFFFFFFF9, 8'd6},
      '{rr(4'h8, 5'd16, 5'd5, 5'd8),       5'd16, 32'h7FFE0000, 8'd6},
      '{rr(4'h9, 5'd17, 5'd1, 5'd2),       5'd17, 32'd7,        8'd6},
      '{rk(4'hA, 5'd18, 5'd1, 16'h000F),   5'd18, 32'd8,        8'd6},
      '{rk(4'h1, 5'd19, 5'd31, 16'd1),     5'd19, 32'hFFFFFFFF, 8'd4},
      '{rk(4'h2, 5'd20, 5'd1, 16'hFFFD),   5'd20, 32'hFFFFFFEB, 8'd4},
      '{rr(4'h0, 5'd31, 5'd1, 5'd2),       5'd31, 32'd0,        8'd7},  // R7
      '{rr(4'h0, 5'd21, 5'd31, 5'd1),      5'd21, 32'd7,        8'd7}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rdreg(input logic [4:0] r, output logic [31:0] v);
      dbg_sel = r;
      #0.5;
      v = dbg_val;
   endtask

   // inputs change at a falling edge; the result is sampled one falling edge later
   task automatic issue(input logic [31:0] w, input logic v);
      instr = w;
      instr_valid = v;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] pre;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 illegal", {31'b0, illegal}, 32'd0);
      for (int i = 0; i < 32; i++) begin
         rdreg(5'(i), v);
         if (i == 0 || i == 17 || i == 31) check("R1 reg", v, 32'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].ins, 1'b1);
         rdreg(VEC[i].chk, v);
         total++;
         if (v !== VEC[i].exp) begin
            bad++;
            $display("FAIL R%0d vector %0d: actual=%h expected=%h", VEC[i].req, i, v, VEC[i].exp);
         end
         check("R8 no flag", {31'b0, illegal}, 32'd0);
      end

      // R8: opcode with bit 31 clear targeting r1
      rdreg(5'd1, pre);
      issue({6'b000000, 5'd1, 5'd2, 5'd2, 11'b0}, 1'b1);
      check("R8 flag high", {31'b0, illegal}, 32'd1);
      rdreg(5'd1, v);
      check("R8 r1 unchanged", v, pre);
      @(negedge clk);
      check("R8 flag one cycle", {31'b0, illegal}, 32'd0);
      // R8: unimplemented function code 0011 (divide slot)
      issue(rr(4'h3, 5'd2, 5'd1, 5'd1), 1'b1);
      check("R8 flag fn3", {31'b0, illegal}, 32'd1);
      rdreg(5'd2, v);
      check("R8 r2 unchanged", v, 32'd5);
      // R9: strobe low
      issue(rk(4'h0, 5'd1, 5'd31, 16'h1234), 1'b0);
      check("R9 no flag", {31'b0, illegal}, 32'd0);
      rdreg(5'd1, v);
      check("R9 r1 unchanged", v, 32'd7);
      // R10: dependent chain
      issue(rk(4'h0, 5'd22, 5'd1, 16'd1), 1'b1);
      issue(rr(4'h2, 5'd22, 5'd22, 5'd22), 1'b1);
      rdreg(5'd22, v);
      check("R10 chain", v, 32'd64);
      // R1: reset again clears
      rst_n = 1'b0;
      @(negedge clk);
      rdreg(5'd22, v);
      check("R1 reset clears", v, 32'd0);
      rst_n = 1'b1;
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (100000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule